// File: doc/BRIEF.md
# Logical Shift Decode-Execute Unit

This unit takes one 32-bit instruction word and handles two families of logical shift instructions. The immediate family is written as a special case of the unsigned bitfield-move encoding. The register family takes its shift amount from a second source register. A size flag in bit 31 selects either 64-bit operation or 32-bit operation on the low half of the operands. The unit decodes the word, drives the two register-read indices, masks the read data, reduces the shift amount modulo the operand size and shifts the value through a barrel shifter. It then presents a writeback (index, data, enable), the next program counter and the valid and illegal flags.

Every output depends only on the instruction word, the read data and the program counter. There is no state in the unit. A surrounding core connects the read-index outputs to its register file, feeds the data back and commits the writeback.

Top module: `shift_unit`

## Requirements
- R1: An immediate-form word has bits 30:29 = 10 and bits 28:23 = 100110. Its fields are N = bit 22, immr = bits 21:16 and imms = bits 15:10. It is accepted only when N equals the size flag (bit 31). A mismatch raises illegal_o with valid_o and wb_en_o low.
- R2: In the immediate form, imms equal to 111111 (size flag 1) or 011111 (size flag 0) selects a logical right shift by immr reduced modulo the operand size.
- R3: In the immediate form, when R2 does not apply and immr equals imms + 1, the word selects a left shift by ((size − 1) − imms) reduced modulo the operand size. The subtraction wraps in 6 bits. Every other immr/imms pair is illegal.
- R4: A register-form word has bits 30:29 = 00, bits 28:21 = 11010110 and bits 15:12 = 0010. Its op2 field is bits 11:10: 00 selects a left shift, 01 selects a right shift, and 10 or 11 is illegal.
- R5: In the register form, the shift amount is the value of register Rm (bits 20:16) reduced modulo 64 when the size flag is 1, and modulo 32 when it is 0.
- R6: With the size flag 1, the full 64-bit value of Rn (bits 9:5) is shifted. With the size flag 0, only the low 32 bits are shifted, vacated bits fill with zeros, and wb_data_o[63:32] is zero.
- R7: next_pc_o equals pc_i + 4 when valid_o is high, and equals pc_i otherwise.
- R8: A read of index 31 on either port gives zero. An accepted word whose destination is 31 keeps valid_o high but holds wb_en_o low.
- R9: A word that matches neither family drives valid_o, illegal_o and wb_en_o all low. valid_o and illegal_o are never high together.
- R10: wb_idx_o carries Rd (bits 4:0). rd_a_idx_o carries Rn and rd_b_idx_o carries bits 20:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| pc_i | input | 64 | Current program counter |
| rd_a_idx_o | output | 5 | Read index of the value to shift (Rn) |
| rd_a_data_i | input | 64 | Read data for rd_a_idx_o |
| rd_b_idx_o | output | 5 | Read index of the shift-amount register (Rm) |
| rd_b_data_i | input | 64 | Read data for rd_b_idx_o |
| wb_idx_o | output | 5 | Destination index |
| wb_data_o | output | 64 | Shift result |
| wb_en_o | output | 1 | Writeback enable |
| next_pc_o | output | 64 | Next program counter |
| valid_o | output | 1 | Word accepted as a shift |
| illegal_o | output | 1 | Word in a shift family but with illegal fields |

## Verification
The checker evaluates a set of invariants on every input combination. valid_o and illegal_o never rise together, and a writeback never happens without validity or to index 31. The program counter advances by exactly 4 on acceptance, a 32-bit result always has a clear upper half, and an immediate word whose N bit disagrees with the size flag is never accepted. The actual shift results cannot be shown by these invariants. The immediate-field decoding, the modulo reduction of large register amounts and the masking of index-31 reads are shown only by the bench's sweeps, which check every data value against an arithmetic model.

// File: rtl/shift_pkg.sv
package shift_pkg;

   localparam int unsigned INSTR_W = 32;
   localparam int unsigned IDX_W   = 5;
   localparam int unsigned FIELD_W = 6;

   typedef enum logic [1:0] {
      SHK_NONE = 2'd0,
      SHK_LEFT = 2'd1,
      SHK_RIGHT = 2'd2
   } shift_kind_e;

   typedef struct packed {
      logic              matched;   // word belongs to one of the two families
      logic              legal;     // fields form an accepted shift
      logic              reg_form;  // amount comes from register Rm
      logic              wide;      // 64-bit operation
      shift_kind_e       kind;
      logic [FIELD_W-1:0] imm_amt;  // raw amount for the immediate form
      logic [IDX_W-1:0]  rd;
      logic [IDX_W-1:0]  rn;
      logic [IDX_W-1:0]  rm;
   } shift_dec_t;

   localparam logic [1:0] IMM_TOP2   = 2'b10;
   localparam logic [5:0] IMM_OPC    = 6'b100110;
   localparam logic [1:0] REG_TOP2   = 2'b00;
   localparam logic [7:0] REG_OPC    = 8'b11010110;
   localparam logic [3:0] REG_SUBOPC = 4'b0010;

endpackage

// File: rtl/shift_decoder.sv
module shift_decoder
   import shift_pkg::*;
(
   input  logic [INSTR_W-1:0] instr_i,
   output shift_dec_t         dec_o
);

   logic                sf;
   logic                n_bit;
   logic [FIELD_W-1:0]  immr;
   logic [FIELD_W-1:0]  imms;
   logic [FIELD_W-1:0]  ones;
   logic [1:0]          op2;
   logic                imm_hit;
   logic                reg_hit;
   logic                imm_right;
   logic                imm_left;

   assign sf    = instr_i[31];
   assign n_bit = instr_i[22];
   assign immr  = instr_i[21:16];
   assign imms  = instr_i[15:10];
   assign op2   = instr_i[11:10];
   assign ones  = sf ? 6'h3f : 6'h1f;

   assign imm_hit = (instr_i[30:29] == IMM_TOP2) && (instr_i[28:23] == IMM_OPC);
   assign reg_hit = (instr_i[30:29] == REG_TOP2) && (instr_i[28:21] == REG_OPC)
                    && (instr_i[15:12] == REG_SUBOPC);

   assign imm_right = (imms == ones);
   assign imm_left  = !imm_right && (({1'b0, imms} + 7'd1) == {1'b0, immr});

   always_comb begin
      dec_o          = '0;
      dec_o.rd       = instr_i[4:0];
      dec_o.rn       = instr_i[9:5];
      dec_o.rm       = instr_i[20:16];
      dec_o.wide     = sf;
      dec_o.matched  = imm_hit || reg_hit;
      dec_o.reg_form = reg_hit;
      dec_o.kind     = SHK_NONE;
      if (imm_hit) begin
         if (n_bit == sf) begin
            if (imm_right) begin
               dec_o.kind    = SHK_RIGHT;
               dec_o.imm_amt = immr;
               dec_o.legal   = 1'b1;
            end else if (imm_left) begin
               dec_o.kind    = SHK_LEFT;
               dec_o.imm_amt = ones - imms;
               dec_o.legal   = 1'b1;
            end
         end
      end else if (reg_hit) begin
         unique case (op2)
            2'b00: begin
               dec_o.kind  = SHK_LEFT;
               dec_o.legal = 1'b1;
            end
            2'b01: begin
               dec_o.kind  = SHK_RIGHT;
               dec_o.legal = 1'b1;
            end
            default: dec_o.legal = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/shift_operand.sv
module shift_operand
   import shift_pkg::*;
#(
   parameter int unsigned XLEN     = 64,
   parameter int unsigned ZERO_IDX = 31,
   localparam int unsigned AMT_W   = $clog2(XLEN),
   localparam int unsigned HALF    = XLEN / 2
) (
   input  shift_dec_t          dec_i,
   input  logic [XLEN-1:0]     rd_a_data_i,
   input  logic [XLEN-1:0]     rd_b_data_i,
   output logic [XLEN-1:0]     src_o,
   output logic [AMT_W-1:0]    amt_o
);

   logic [XLEN-1:0]  a_val;
   logic [XLEN-1:0]  b_val;
   logic [XLEN-1:0]  b_low;
   logic [AMT_W-1:0] raw_amt;

   // Index ZERO_IDX reads as zero on both ports.
   assign a_val = (dec_i.rn == IDX_W'(ZERO_IDX)) ? '0 : rd_a_data_i;
   assign b_val = (dec_i.rm == IDX_W'(ZERO_IDX)) ? '0 : rd_b_data_i;

   // Reduction modulo XLEN keeps only the low AMT_W bits of the register.
   assign b_low   = b_val & XLEN'((1 << AMT_W) - 1);
   assign raw_amt = dec_i.reg_form ? b_low[AMT_W-1:0] : AMT_W'(dec_i.imm_amt);

   // Narrow mode: operate on the low half, amount modulo HALF.
   always_comb begin
      if (dec_i.wide) begin
         src_o = a_val;
         amt_o = raw_amt;
      end else begin
         src_o = {{HALF{1'b0}}, a_val[HALF-1:0]};
         amt_o = {1'b0, raw_amt[AMT_W-2:0]};
      end
   end

endmodule

// File: rtl/shift_barrel.sv
module shift_barrel #(
   parameter int unsigned XLEN = 64,
   parameter int unsigned IMPL = 0,   // 0: log-staged mux network, 1: operator form
   localparam int unsigned AMT_W = $clog2(XLEN)
) (
   input  logic [XLEN-1:0]  val_i,
   input  logic [AMT_W-1:0] amt_i,
   input  logic             left_i,
   output logic [XLEN-1:0]  res_o
);

   initial begin
      if (IMPL > 1) $error("shift_barrel: IMPL must be 0 or 1");
      if ((1 << AMT_W) != XLEN) $error("shift_barrel: XLEN must be a power of two");
   end

   generate
      if (IMPL == 0) begin : g_staged
         logic [XLEN-1:0] rev_in;
         logic [XLEN-1:0] rev_out;
         logic [XLEN-1:0] stage [AMT_W+1];

         // Left shifts reuse the right-shift network on a bit-reversed value.
         for (genvar b = 0; b < XLEN; b++) begin : g_rev
            assign rev_in[b]  = val_i[XLEN-1-b];
            assign rev_out[b] = stage[AMT_W][XLEN-1-b];
         end

         assign stage[0] = left_i ? rev_in : val_i;

         for (genvar s = 0; s < AMT_W; s++) begin : g_stage
            assign stage[s+1] = amt_i[s] ? (stage[s] >> (1 << s)) : stage[s];
         end

         assign res_o = left_i ? rev_out : stage[AMT_W];
      end else begin : g_operator
         assign res_o = left_i ? (val_i << amt_i) : (val_i >> amt_i);
      end
   endgenerate

endmodule

// File: rtl/shift_unit.sv
module shift_unit
   import shift_pkg::*;
#(
   parameter int unsigned XLEN     = 64,
   parameter int unsigned PC_STEP  = 4,
   parameter int unsigned ZERO_IDX = 31,
   parameter int unsigned SHIFTER  = 0
) (
   input  logic [31:0]   instr_i,
   input  logic [63:0]   pc_i,
   output logic [4:0]    rd_a_idx_o,
   input  logic [63:0]   rd_a_data_i,
   output logic [4:0]    rd_b_idx_o,
   input  logic [63:0]   rd_b_data_i,
   output logic [4:0]    wb_idx_o,
   output logic [63:0]   wb_data_o,
   output logic          wb_en_o,
   output logic [63:0]   next_pc_o,
   output logic          valid_o,
   output logic          illegal_o
);

   localparam int unsigned AMT_W = $clog2(XLEN);
   localparam int unsigned HALF  = XLEN / 2;

   initial begin
      if (XLEN != 64) $error("shift_unit: XLEN must be 64");
      if (PC_STEP == 0) $error("shift_unit: PC_STEP must be nonzero");
      if (ZERO_IDX >= (1 << IDX_W)) $error("shift_unit: ZERO_IDX out of range");
      if (SHIFTER > 1) $error("shift_unit: SHIFTER must be 0 or 1");
   end

   shift_dec_t          dec;
   logic [XLEN-1:0]     src;
   logic [AMT_W-1:0]    amt;
   logic [XLEN-1:0]     shifted;

   shift_decoder u_dec (
      .instr_i (instr_i),
      .dec_o   (dec)
   );

   shift_operand #(
      .XLEN     (XLEN),
      .ZERO_IDX (ZERO_IDX)
   ) u_opnd (
      .dec_i       (dec),
      .rd_a_data_i (rd_a_data_i),
      .rd_b_data_i (rd_b_data_i),
      .src_o       (src),
      .amt_o       (amt)
   );

   shift_barrel #(
      .XLEN (XLEN),
      .IMPL (SHIFTER)
   ) u_bsh (
      .val_i  (src),
      .amt_i  (amt),
      .left_i (dec.kind == SHK_LEFT),
      .res_o  (shifted)
   );

   assign rd_a_idx_o = dec.rn;
   assign rd_b_idx_o = dec.rm;
   assign wb_idx_o   = dec.rd;

   assign valid_o   = dec.matched && dec.legal;
   assign illegal_o = dec.matched && !dec.legal;
   assign wb_en_o   = valid_o && (dec.rd != IDX_W'(ZERO_IDX));
   assign wb_data_o = dec.wide ? shifted : {{HALF{1'b0}}, shifted[HALF-1:0]};
   assign next_pc_o = valid_o ? (pc_i + 64'(PC_STEP)) : pc_i;

endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk (
   input logic [31:0] instr_i,
   input logic [63:0] pc_i,
   input logic [4:0]  wb_idx_o,
   input logic [63:0] wb_data_o,
   input logic        wb_en_o,
   input logic [63:0] next_pc_o,
   input logic        valid_o,
   input logic        illegal_o
);

   logic imm_family;
   assign imm_family = (instr_i[30:23] == 8'b10100110);

   always_comb begin
      if (!$isunknown({instr_i, pc_i})) begin
         AST_FLAGS_EXCLUSIVE: assert (!(valid_o && illegal_o)); // R9
         AST_WB_NEEDS_VALID: assert (!wb_en_o || valid_o); // R8
         AST_NO_WB_ZERO_REG: assert (!wb_en_o || (wb_idx_o != 5'd31)); // R8
         AST_PC_STEP: assert (!valid_o || (next_pc_o == pc_i + 64'd4)); // R7
         AST_PC_HOLD: assert (valid_o || (next_pc_o == pc_i)); // R7
         AST_NARROW_UPPER_CLEAR: assert (!(valid_o && !instr_i[31]) || (wb_data_o[63:32] == 32'd0)); // R6
         AST_N_MATCHES_SF: assert (!(imm_family && (instr_i[22] != instr_i[31])) || (!valid_o && illegal_o)); // R1
      end
   end

endmodule

bind shift_unit shift_unit_chk u_chk (
   .instr_i   (instr_i),
   .pc_i      (pc_i),
   .wb_idx_o  (wb_idx_o),
   .wb_data_o (wb_data_o),
   .wb_en_o   (wb_en_o),
   .next_pc_o (next_pc_o),
   .valid_o   (valid_o),
   .illegal_o (illegal_o)
);

// File: tb/shift_unit_tb_top.sv
module shift_unit_tb_top;

   logic        clk = 1'b0;
   logic [31:0] instr;
   logic [63:0] pc;
   logic [63:0] a_data;
   logic [63:0] b_data;
   logic [4:0]  a_idx;
   logic [4:0]  b_idx;
   logic [4:0]  wb_idx;
   logic [63:0] wb_data;
   logic        wb_en;
   logic [63:0] next_pc;
   logic        valid;
   logic        illegal;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   shift_unit dut_i (
      .instr_i     (instr),
      .pc_i        (pc),
      .rd_a_idx_o  (a_idx),
      .rd_a_data_i (a_data),
      .rd_b_idx_o  (b_idx),
      .rd_b_data_i (b_data),
      .wb_idx_o    (wb_idx),
      .wb_data_o   (wb_data),
      .wb_en_o     (wb_en),
      .next_pc_o   (next_pc),
      .valid_o     (valid),
      .illegal_o   (illegal)
   );

   function automatic logic [63:0] model(input bit sf, input bit left,
                                         input logic [63:0] v, input int amt);
      logic [31:0] n;
      if (sf) return left ? (v << (amt % 64)) : (v >> (amt % 64));
      n = v[31:0];
      n = left ? (n << (amt % 32)) : (n >> (amt % 32));
      return {32'd0, n};
   endfunction

   task automatic apply(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] p);
      @(posedge clk);
      instr  = w;
      a_data = a;
      b_data = b;
      pc     = p;
      @(negedge clk);
   endtask

   task automatic check(input string req, input bit exp_v, input bit exp_ill,
                        input bit exp_we, input logic [63:0] exp_d, input bit chk_d);
      logic [63:0] exp_pc;
      bit bad;
      exp_pc = exp_v ? pc + 64'd4 : pc;
      bad = (valid !== exp_v) || (illegal !== exp_ill) || (wb_en !== exp_we)
            || (next_pc !== exp_pc) || (chk_d && (wb_data !== exp_d));
      tests++;
      if (bad) begin
         fails++;
         $display("FAIL %s instr=%h: v/ill/we=%b%b%b data=%h pc=%h, expected %b%b%b data=%h pc=%h",
                  req, instr, valid, illegal, wb_en, wb_data, next_pc,
                  exp_v, exp_ill, exp_we, exp_d, exp_pc);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] pat;
      instr = 32'd0; pc = 64'd0; a_data = 64'd0; b_data = 64'd0;

      // R9: reset-like idle word matches no family
      apply(32'h0000_0000, 64'h1, 64'h1, 64'h1000);
      check("R9", 0, 0, 0, 64'd0, 0);
      apply(32'hFFFF_FFFF, 64'h1, 64'h1, 64'h2000);
      check("R9", 0, 0, 0, 64'd0, 0);
      // R4: register form with wrong bits 15:12 is unmatched
      apply({1'b1, 2'b00, 8'b11010110, 5'd2, 4'b0011, 2'b00, 5'd3, 5'd4}, 64'h5, 64'h1, 64'h40);
      check("R4", 0, 0, 0, 64'd0, 0);
      // R1: wrong opcode bits 28:23 is unmatched
      apply({1'b1, 2'b10, 6'b100111, 1'b1, 6'd4, 6'd63, 5'd3, 5'd4}, 64'h5, 64'h1, 64'h40);
      check("R1", 0, 0, 0, 64'd0, 0);

      // R1, R2, R3, R6, R7, R10: full sweep of the immediate form
      for (int sf = 0; sf < 2; sf++) begin
         for (int nb = 0; nb < 2; nb++) begin
            for (int r = 0; r < 64; r++) begin
               for (int s = 0; s < 64; s++) begin
                  bit ok;
                  bit left;
                  int amt;
                  int ones;
                  ones = sf ? 63 : 31;
                  pat  = 64'hF0E1_D2C3_B4A5_9687 ^ {r[31:0], s[31:0]} ^ (64'h1 << (r ^ s));
                  ok   = 1'b0; left = 1'b0; amt = 0;
                  if (nb == sf) begin
                     if (s == ones) begin
                        ok = 1'b1; amt = r;
                     end else if (s + 1 == r) begin
                        ok = 1'b1; left = 1'b1;
                        amt = sf ? (63 - s) : ((31 - (s % 32)) + 32) % 32;
                     end
                  end
                  apply({sf[0], 2'b10, 6'b100110, nb[0], r[5:0], s[5:0], 5'd7, 5'd9},
                        pat, 64'hFFFF, 64'h8000 + 64'(r * 4));
                  check(ok ? (left ? "R3" : "R2") : "R1", ok, !ok, ok,
                        model(sf[0], left, pat, amt), ok);
                  if (ok && wb_idx !== 5'd9) begin
                     tests++; fails++;
                     $display("FAIL R10 wb_idx=%0d expected 9", wb_idx);
                  end
               end
            end
         end
      end

      // R4, R5, R6: register form sweep over op2 and amounts beyond the size
      for (int sf = 0; sf < 2; sf++) begin
         for (int op = 0; op < 4; op++) begin
            for (int am = 0; am < 128; am++) begin
               for (int p = 0; p < 3; p++) begin
                  bit ok;
                  logic [63:0] bv;
                  ok  = (op < 2);
                  pat = (p == 0) ? 64'hFFFF_FFFF_FFFF_FFFF :
                        (p == 1) ? 64'h8000_0001_8000_0001 : 64'h0123_4567_89AB_CDEF;
                  bv  = {32'hA5A5_0000, 25'd0, am[6:0]};
                  apply({sf[0], 2'b00, 8'b11010110, 5'd12, 4'b0010, op[1:0], 5'd13, 5'd14},
                        pat, bv, 64'hFFFF_FFFF_FFFF_FFFC);
                  check(ok ? "R5" : "R4", ok, !ok, ok, model(sf[0], op == 0, pat, am), ok);
               end
            end
         end
      end

      // R10: read indices presented
      apply({1'b1, 2'b00, 8'b11010110, 5'd21, 4'b0010, 2'b01, 5'd22, 5'd23}, 64'h1, 64'h1, 64'h0);
      tests++;
      if (a_idx !== 5'd22 || b_idx !== 5'd21 || wb_idx !== 5'd23) begin
         fails++;
         $display("FAIL R10 idx a/b/wb=%0d/%0d/%0d expected 22/21/23", a_idx, b_idx, wb_idx);
      end

      // R8: Rn = 31 reads zero
      apply({1'b1, 2'b00, 8'b11010110, 5'd2, 4'b0010, 2'b00, 5'd31, 5'd4}, 64'hDEAD_BEEF, 64'd3, 64'h10);
      check("R8", 1, 0, 1, 64'd0, 1);
      // R8: Rm = 31 reads zero, so amount is 0
      apply({1'b1, 2'b00, 8'b11010110, 5'd31, 4'b0010, 2'b00, 5'd5, 5'd4}, 64'h1234, 64'd9, 64'h10);
      check("R8", 1, 0, 1, 64'h1234, 1);
      // R8: destination 31 accepted without write
      apply({1'b0, 2'b10, 6'b100110, 1'b0, 6'd3, 6'd31, 5'd5, 5'd31}, 64'hF0, 64'd0, 64'h20);
      check("R8", 1, 0, 0, 64'h1E, 1);
      // R6: 32-bit left shift drops bits past bit 31
      apply({1'b0, 2'b10, 6'b100110, 1'b0, 6'd1, 6'd0, 5'd5, 5'd6}, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'h30);
      check("R6", 1, 0, 1, 64'h0000_0000_8000_0000, 1);
      // R7: illegal word leaves PC unchanged
      apply({1'b1, 2'b10, 6'b100110, 1'b0, 6'd3, 6'd63, 5'd5, 5'd6}, 64'h1, 64'd0, 64'h50);
      check("R7", 0, 1, 0, 64'd0, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule